// File: doc/BRIEF.md
# UART Baud Clock Generator

This block turns the system clock, or a slower clock supplied from outside, into the two timing strobes a UART needs. One is an oversampling strobe that the receiver and transmitter use to sample and shape each bit. The other is a bit strobe that fires once for every sixteen oversampling strobes. Both are enables that stay in the system clock domain. The block never produces a derived clock.

On the internal path a two-bit source code picks one of three sources: the system clock itself, the system clock divided by a fixed eight, or a prescaled clock. The prescaler divides by twice a four-bit setting, and a setting of zero passes the clock through undivided. The chosen source then goes through an 8-bit reload divider that produces one oversampling strobe per (m+1) source pulses. An external-mode select can replace the whole internal source with the rising edges of a pin. That pin goes through a two-flop synchroniser and an edge detector first. The bit period is therefore 16·(m+1) source periods.

Any change to the divider setting, the prescaler setting, the source code, the external select or the enable restarts every counter. The first strobe after a change therefore comes one full new period later.

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all counters clear and both strobes are low. After release with `enable` high, the first oversampling strobe appears exactly one period P after the first edge that samples `rst_n` high.
- R2: With `ext_sel`=0 and `src_sel`=0, the period is P = m+1 system clocks. Code 3 is reserved and behaves exactly like code 0.
- R3: With `ext_sel`=0 and `src_sel`=1, the source is the system clock divided by 8, so P = 8·(m+1).
- R4: With `ext_sel`=0 and `src_sel`=2, the source is prescaled. With n=0 the period is P = m+1. With n in 1..15 the period is P = 2n·(m+1).
- R5: The full divider range works. With m=255 and the undivided source, P is 256.
- R6: With `ext_sel`=1 the source code and the prescaler are ignored. One oversampling strobe is produced for every (m+1) synchronised rising edges of `ext_clk`.
- R7: Counting from the clock edge that samples a new setting as edge 0, oversampling strobes are high in the cycles after edges P, 2P, 3P and so on. Each strobe lasts one cycle whenever P ≥ 2.
- R8: `bit_tick` is high exactly on every 16th `os_tick` since the last restart, and never without `os_tick`.
- R9: A change of m, n, `src_sel`, `ext_sel` or `enable` restarts all counters. No strobe appears in the cycle after the edge that samples the change, and the next strobe lands at exactly P.
- R10: While `enable` is low, neither strobe is ever produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the generator; low holds all counters cleared |
| ext_sel | input | 1 | 1: rising edges of `ext_clk` are the source |
| src_sel | input | 2 | Internal source: 0 undivided, 1 divide-by-8, 2 prescaled, 3 as 0 |
| presc_n | input | 4 | Prescaler setting n: 0 passes through, else divide by 2n |
| div_m | input | 8 | Reload divider setting m; source pulses per strobe minus one |
| ext_clk | input | 1 | External clock, asynchronous to `clk` |
| os_tick | output | 1 | Oversampling strobe, one clock wide |
| bit_tick | output | 1 | Bit strobe, coincides with every 16th `os_tick` |

## Verification
The bench applies each new setting at an arbitrary phase of the running divider, so it checks the reload behaviour. A design that kept its old count would produce a short or long first period, and the exact-cycle comparison of the strobe pattern would catch it. The boundary settings are covered directly: n=0 against n=15, the reserved source code, and m=255. An off-by-one in the prescaler ratio or the divider limit, or a wrong decode of those settings, shows up as every strobe drifting from its expected cycle. In external mode the bench counts strobes against a known number of pin edges. An edge detector that fired on both edges, or on a level, would double the count or run away. A bit strobe on the wrong oversampling count, or any strobe while the block is disabled, is also reported.

// File: rtl/baud_pkg.sv
// Shared types for the UART baud clock generator.
package baud_pkg;
    // Internal source codes; the order is decoded by baud_src_pulse.
    typedef enum logic [1:0] {
        SRC_FULL  = 2'd0,
        SRC_DIV8  = 2'd1,
        SRC_PRESC = 2'd2,
        SRC_RSVD  = 2'd3
    } src_e;
endpackage

// File: rtl/baud_edge_sync.sv
// Synchronises an asynchronous clock input into the system domain and
// turns each rising edge into a one-cycle enable.
// Assumes the input stays high and low for at least STAGES+1 system clocks.
module baud_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              hist;

    // First synchroniser stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    // Remaining stages of the synchroniser chain.
    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    // Previous synchronised level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= 1'b0;
        else        hist <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~hist;
endmodule

// File: rtl/baud_src_pulse.sv
// Produces one enable per period of the selected source clock: the system
// clock, a fixed division of it, an even-ratio prescaler, or external edges.
// Assumes restart is asserted whenever a setting changes or the block is off.
module baud_src_pulse
    import baud_pkg::*;
#(
    parameter int N_W     = 4,
    parameter int FIX_DIV = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           ext_sel,
    input  logic [1:0]     src_sel,
    input  logic [N_W-1:0] presc_n,
    input  logic           ext_rise,
    output logic           src_en
);
    localparam int PRE_MAX = 2 * ((1 << N_W) - 1);
    localparam int MAXR    = (FIX_DIV > PRE_MAX) ? FIX_DIV : PRE_MAX;
    localparam int CW      = $clog2(MAXR + 1);

    logic [CW-1:0] ratio;
    logic [CW-1:0] cnt;
    logic          last;

    // Decode the source ratio in system clocks per source pulse.
    always_comb begin
        case (src_e'(src_sel))
            SRC_DIV8:  ratio = CW'(FIX_DIV);
            SRC_PRESC: ratio = (presc_n == '0) ? CW'(1) : (CW'(presc_n) << 1);
            default:   ratio = CW'(1);
        endcase
    end

    assign last = (cnt == ratio - CW'(1));

    // Free-running phase counter of the internal source, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (last)         cnt <= '0;
        else                   cnt <= cnt + CW'(1);
    end

    assign src_en = ~restart & (ext_sel ? ext_rise : last);
endmodule

// File: rtl/baud_wrap_cnt.sv
// Counts step pulses and signals a wrap on the pulse that reaches limit,
// giving one wrap per limit+1 steps. Cleared by reset and restart.
module baud_wrap_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt;

    assign wrap = step & ~restart & (cnt == limit);

    // Advance on each step, returning to zero after the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (wrap)         cnt <= '0;
        else if (step)         cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/uart_baud_gen.sv
// UART baud clock generator: source select, (m+1) reload divider and the
// fixed oversampling divider, with registered one-cycle strobes.
// Assumes settings are static except for deliberate writes; any change
// restarts all counters so no truncated period follows.
module uart_baud_gen #(
    parameter int M_W         = 8,
    parameter int N_W         = 4,
    parameter int OVS         = 16,
    parameter int FIX_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           ext_sel,
    input  logic [1:0]     src_sel,
    input  logic [N_W-1:0] presc_n,
    input  logic [M_W-1:0] div_m,
    input  logic           ext_clk,
    output logic           os_tick,
    output logic           bit_tick
);
    localparam int OW    = $clog2(OVS);
    localparam int CFG_W = 4 + N_W + M_W;

    logic [CFG_W-1:0] cfg_now, cfg_q;
    logic             restart, ext_rise, src_en, os_pre, bit_pre;

    assign cfg_now = {enable, ext_sel, src_sel, presc_n, div_m};
    assign restart = ~enable | (cfg_now != cfg_q);

    // Remember the settings of the previous cycle to detect writes.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_now;
    end

    baud_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise)
    );

    baud_src_pulse #(.N_W(N_W), .FIX_DIV(FIX_DIV)) u_src (
        .clk(clk), .rst_n(rst_n), .restart(restart), .ext_sel(ext_sel),
        .src_sel(src_sel), .presc_n(presc_n), .ext_rise(ext_rise),
        .src_en(src_en)
    );

    baud_wrap_cnt #(.W(M_W)) u_mdiv (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(src_en),
        .limit(div_m), .wrap(os_pre)
    );

    baud_wrap_cnt #(.W(OW)) u_odiv (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(os_pre),
        .limit(OW'(OVS - 1)), .wrap(bit_pre)
    );

    // Register the strobes so they leave the block glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else begin
            os_tick  <= os_pre;
            bit_tick <= bit_pre;
        end
    end
endmodule

// File: rtl/baud_gen_chk.sv
// Temporal checks on the baud generator's ports, attached by bind.
module baud_gen_chk #(
    parameter int M_W = 8,
    parameter int N_W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enable,
    input logic           ext_sel,
    input logic [1:0]     src_sel,
    input logic [N_W-1:0] presc_n,
    input logic [M_W-1:0] div_m,
    input logic           os_tick,
    input logic           bit_tick
);
    logic [3+N_W+M_W:0] seen_q;
    logic               changed;
    logic [4:0]         os_cnt;

    assign changed = ~enable | ({enable, ext_sel, src_sel, presc_n, div_m} != seen_q);

    // Track settings seen at the port to spot restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= {enable, ext_sel, src_sel, presc_n, div_m};
    end

    // Count oversampling strobes since the last bit strobe or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || changed)     os_cnt <= '0;
        else if (bit_tick)         os_cnt <= '0;
        else if (os_tick)          os_cnt <= os_cnt + 5'd1;
    end

    a_r8_bit_with_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    a_r8_sixteenth: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !changed) |-> (os_cnt == 5'd15));

    a_r8_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && !changed && os_cnt == 5'd15) |-> bit_tick);

    a_r10_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!os_tick && !bit_tick));

    a_r9_reload_gap: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> !os_tick);
endmodule

bind uart_baud_gen baud_gen_chk #(.M_W(M_W), .N_W(N_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ext_sel(ext_sel),
    .src_sel(src_sel), .presc_n(presc_n), .div_m(div_m),
    .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/uart_baud_gen_test.sv
// Self-checking bench for uart_baud_gen: seeded random settings applied at
// arbitrary divider phases, plus directed corner cases.
module uart_baud_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       ext_sel = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] presc_n = 4'd0;
    logic [7:0] div_m = 8'd0;
    logic       ext_clk = 1'b0;
    logic       os_tick, bit_tick;

    int checks = 0;
    int fails  = 0;
    int os_n, bit_n;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_baud_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ext_sel(ext_sel),
        .src_sel(src_sel), .presc_n(presc_n), .div_m(div_m),
        .ext_clk(ext_clk), .os_tick(os_tick), .bit_tick(bit_tick)
    );

    // Period in system clocks from the requirements (R2, R3, R4).
    function automatic int exp_period(input int src, input int n, input int m);
        int d;
        case (src)
            1:       d = 8;
            2:       d = (n == 0) ? 1 : 2 * n;
            default: d = 1;
        endcase
        return d * (m + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        if (os_tick)  os_n++;
        if (bit_tick) bit_n++;
    endtask

    // Compare the strobe pattern cycle by cycle after a new setting (R7, R8).
    task automatic measure(input int p, input int w, input string req);
        int os_bad = 0;
        int bit_bad = 0;
        int first_bad = -1;
        for (int j = 0; j <= w; j++) begin
            bit eo, eb;
            @(posedge clk);
            @(negedge clk);
            eo = (j > 0) && (j % p == 0);
            eb = (j > 0) && (j % (16 * p) == 0);
            if (os_tick !== eo) begin
                os_bad++;
                if (first_bad < 0) first_bad = j;
            end
            if (bit_tick !== eb) bit_bad++;
        end
        chk(os_bad == 0, {req, " R7 os_tick pattern (first bad cycle in actual)"}, first_bad, -1);
        chk(bit_bad == 0, {req, " R8 bit_tick pattern (mismatches)"}, bit_bad, 0);
    endtask

    task automatic apply(input int src, input int n, input int m, input string req);
        int p;
        if (enable && !ext_sel && src_sel == 2'(src) && presc_n == 4'(n) && div_m == 8'(m))
            m = m ^ 1;
        src_sel = 2'(src);
        presc_n = 4'(n);
        div_m   = 8'(m);
        p = exp_period(src, n, m);
        measure(p, 16 * p + 3, req);
    endtask

    // External mode: count strobes for k synchronised edges (R6).
    task automatic ext_run(input int m, input int k);
        ext_clk = 1'b0;
        ext_sel = 1'b1;
        src_sel = 2'd1;
        presc_n = 4'd9;
        div_m   = 8'(m);
        for (int i = 0; i < 4; i++) cycle();
        os_n = 0;
        bit_n = 0;
        for (int e = 0; e < k; e++) begin
            ext_clk = 1'b1;
            for (int i = 0; i < 3; i++) cycle();
            ext_clk = 1'b0;
            for (int i = 0; i < 3; i++) cycle();
        end
        for (int i = 0; i < 4; i++) cycle();
        chk(os_n == k / (m + 1), "R6 external os_tick count", os_n, k / (m + 1));
        chk(bit_n == k / (16 * (m + 1)), "R6 R8 external bit_tick count", bit_n, k / (16 * (m + 1)));
    endtask

    initial begin
        void'($urandom(32'd20240917));
        @(negedge clk);
        enable = 1'b1;
        div_m  = 8'd3;
        os_n = 0;
        bit_n = 0;
        for (int i = 0; i < 5; i++) cycle();
        chk(os_n == 0 && bit_n == 0, "R1 strobes low in reset", os_n + bit_n, 0);
        rst_n = 1'b1;
        measure(4, 70, "R1 first period after reset");

        apply(0, 0, 255, "R5 m=255");
        apply(3, 7, 2, "R2 reserved code");
        apply(0, 0, 0, "R2 undivided m=0");
        apply(1, 0, 0, "R3 divide-by-8");
        apply(1, 4, 5, "R3 divide-by-8 m=5");
        apply(2, 0, 5, "R4 n=0 pass-through");
        apply(2, 15, 0, "R4 n=15");
        apply(2, 1, 2, "R4 n=1");

        for (int it = 0; it < 20; it++) begin
            apply(int'($urandom % 4), int'($urandom % 16), int'($urandom % 4),
                  "R9 random reload");
        end

        ext_run(0, 32);
        ext_run(3, 32);
        ext_sel = 1'b0;

        enable = 1'b0;
        os_n = 0;
        bit_n = 0;
        for (int i = 0; i < 50; i++) cycle();
        div_m = 8'd0;
        src_sel = 2'd0;
        for (int i = 0; i < 100; i++) cycle();
        chk(os_n == 0 && bit_n == 0, "R10 no strobe while disabled", os_n + bit_n, 0);

        enable = 1'b1;
        div_m = 8'd1;
        measure(2, 40, "R9 enable restart");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule